// File: doc/BRIEF.md
# Staged Pattern Matcher Array with Priority Result Collection

This block arranges many small matchers into a grid of pipelines and stages. A character stream enters at the head of the first pipeline. The character then moves one registered hop at a time, first across to the head of each following pipeline and then down through the stages of each pipeline. No stage ever sees a globally broadcast input. Each stage holds a cluster of up to 16 matcher slots. In this build each slot is a stub comparator: it fires when every bit of its own constant mask is present in the character. The mask for a slot is its flat index plus one, where the flat index is (pipe * NUM_STAGES + stage) * SLOTS + slot.

Each stage picks the lowest-numbered slot that fires. It then merges that pick with the result arriving from the stage above it, and the earlier stage always wins. The final results of the pipelines are merged again through a registered chain in which the lower-numbered pipeline wins. As a result, the output for each input character is the single highest-priority matcher anywhere in the array. The output is a match flag plus an identifier formed from the pipeline, stage and slot of the winner. Results from every stage and pipeline line up on the same input character.

Top module: `match_array`

## Requirements
- R1: While rst_ni is low and until the first valid character has passed through, match_o is 0 and id_o is 0.
- R2: The result for a character presented with valid_i high at a clock edge appears on match_o/id_o exactly NUM_PIPES+NUM_STAGES+1 rising edges later (5 with defaults), with one result per cycle.
- R3: Slot (p,s,k) fires for character c when (c & M) == M, where M = ((p*NUM_STAGES+s)*SLOTS+k)+1 truncated to CHAR_W bits; match_o is 1 exactly when some slot fires.
- R4: Within one stage, the lowest-numbered firing slot is reported.
- R5: Within one pipeline, a firing slot in a lower-numbered stage beats any slot in a later stage.
- R6: A firing slot in a lower-numbered pipeline beats any slot in a higher-numbered pipeline.
- R7: id_o = {pipe, stage, slot}, with the pipe field in the top PW bits, the stage field in the next SW bits and the slot field in the low KW bits; each width is clog2 of its count, and at least 1.
- R8: When no slot fires for a valid character, match_o is 0 and id_o is 0.
- R9: A character presented with valid_i low produces match_o 0 and id_o 0, whatever its value.
- R10: Back-to-back characters each receive their own independent result in consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Character qualifier |
| char_i | input | CHAR_W | Input character |
| match_o | output | 1 | Some matcher fired for the aligned character |
| id_o | output | ID_W | {pipe, stage, slot} of the winning matcher, 0 when no match |

## Verification
Every result is due exactly NUM_PIPES+NUM_STAGES+1 edges after the edge that captures its character. The bench drives each character one time unit after a rising edge. It then checks the output at the falling edge of the iteration that lies that many edges later, using a fixed index offset into the stimulus table. Every character value is swept back to back, with valid low on a regular subset. Directed values separate the slot, stage and pipeline priority rules.

// File: rtl/match_pkg.sv
package match_pkg;
  function automatic int unsigned flat_idx(int unsigned p, int unsigned s, int unsigned k,
                                           int unsigned stages, int unsigned slots);
    return (p * stages + s) * slots + k;
  endfunction

  function automatic int unsigned idx_w(int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/prio_enc.sv
module prio_enc #(
  parameter int unsigned N  = 4,
  parameter int unsigned KW = 2
) (
  input  logic [N-1:0]  req_i,
  output logic          any_o,
  output logic [KW-1:0] idx_o
);
  always_comb begin
    idx_o = '0;
    for (int k = N - 1; k >= 0; k--) begin
      if (req_i[k]) idx_o = KW'(k);
    end
  end
  assign any_o = |req_i;
endmodule

// File: rtl/match_stage.sv
module match_stage #(
  parameter int unsigned CHAR_W    = 8,
  parameter int unsigned SLOTS     = 4,
  parameter int unsigned STAGES    = 2,
  parameter int unsigned PIPE_IDX  = 0,
  parameter int unsigned STAGE_IDX = 0,
  parameter int unsigned PW        = 1,
  parameter int unsigned SW        = 1,
  parameter int unsigned KW        = 2,
  parameter int unsigned ID_W      = PW + SW + KW
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              vld_i,
  input  logic [CHAR_W-1:0] chr_i,
  input  logic              prev_hit_i,
  input  logic [ID_W-1:0]   prev_id_i,
  output logic              hit_o,
  output logic [ID_W-1:0]   id_o
);
  logic [SLOTS-1:0] fire;
  logic             loc_any;
  logic [KW-1:0]    loc_k;
  logic [ID_W-1:0]  loc_id;

  for (genvar k = 0; k < SLOTS; k++) begin : g_slot
    localparam int unsigned G = match_pkg::flat_idx(PIPE_IDX, STAGE_IDX, k, STAGES, SLOTS);
    localparam logic [CHAR_W-1:0] MASK = CHAR_W'(G + 1);
    assign fire[k] = vld_i && ((chr_i & MASK) == MASK);
  end

  prio_enc #(.N(SLOTS), .KW(KW)) u_enc (
    .req_i (fire),
    .any_o (loc_any),
    .idx_o (loc_k)
  );

  assign loc_id = {PW'(PIPE_IDX), SW'(STAGE_IDX), loc_k};

  // earlier stage result always wins
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hit_o <= 1'b0;
      id_o  <= '0;
    end else begin
      hit_o <= prev_hit_i | loc_any;
      id_o  <= prev_hit_i ? prev_id_i : (loc_any ? loc_id : '0);
    end
  end
endmodule

// File: rtl/match_array.sv
module match_array #(
  parameter int unsigned NUM_PIPES  = 2,
  parameter int unsigned NUM_STAGES = 2,
  parameter int unsigned SLOTS      = 4,
  parameter int unsigned CHAR_W     = 8,
  localparam int unsigned PW   = match_pkg::idx_w(NUM_PIPES),
  localparam int unsigned SW   = match_pkg::idx_w(NUM_STAGES),
  localparam int unsigned KW   = match_pkg::idx_w(SLOTS),
  localparam int unsigned ID_W = PW + SW + KW
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [CHAR_W-1:0] char_i,
  output logic              match_o,
  output logic [ID_W-1:0]   id_o
);
  logic [NUM_PIPES-1:0]                               h_vld;
  logic [NUM_PIPES-1:0][CHAR_W-1:0]                   h_chr;
  logic [NUM_PIPES-1:0][NUM_STAGES-1:0]               s_vld;
  logic [NUM_PIPES-1:0][NUM_STAGES-1:0][CHAR_W-1:0]   s_chr;
  logic [NUM_PIPES-1:0][NUM_STAGES:0]                 r_hit;
  logic [NUM_PIPES-1:0][NUM_STAGES:0][ID_W-1:0]       r_id;
  logic [NUM_PIPES-1:0]                               x_hit;
  logic [NUM_PIPES-1:0][ID_W-1:0]                     x_id;

  for (genvar p = 0; p < NUM_PIPES; p++) begin : g_pipe
    logic              hv_q;
    logic [CHAR_W-1:0] hc_q;
    logic              xh_q;
    logic [ID_W-1:0]   xi_q;

    // horizontal hop: head of pipe p is one cycle behind pipe p-1
    if (p == 0) begin : g_head0
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          hv_q <= 1'b0;
          hc_q <= '0;
        end else begin
          hv_q <= valid_i;
          hc_q <= char_i;
        end
      end
    end else begin : g_headn
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          hv_q <= 1'b0;
          hc_q <= '0;
        end else begin
          hv_q <= h_vld[p-1];
          hc_q <= h_chr[p-1];
        end
      end
    end
    assign h_vld[p] = hv_q;
    assign h_chr[p] = hc_q;

    assign r_hit[p][0] = 1'b0;
    assign r_id[p][0]  = '0;

    for (genvar s = 0; s < NUM_STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        assign s_vld[p][s] = h_vld[p];
        assign s_chr[p][s] = h_chr[p];
      end else begin : g_fwd
        logic              fv_q;
        logic [CHAR_W-1:0] fc_q;
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) begin
            fv_q <= 1'b0;
            fc_q <= '0;
          end else begin
            fv_q <= s_vld[p][s-1];
            fc_q <= s_chr[p][s-1];
          end
        end
        assign s_vld[p][s] = fv_q;
        assign s_chr[p][s] = fc_q;
      end

      match_stage #(
        .CHAR_W(CHAR_W), .SLOTS(SLOTS), .STAGES(NUM_STAGES),
        .PIPE_IDX(p), .STAGE_IDX(s), .PW(PW), .SW(SW), .KW(KW), .ID_W(ID_W)
      ) u_stage (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .vld_i      (s_vld[p][s]),
        .chr_i      (s_chr[p][s]),
        .prev_hit_i (r_hit[p][s]),
        .prev_id_i  (r_id[p][s]),
        .hit_o      (r_hit[p][s+1]),
        .id_o       (r_id[p][s+1])
      );
    end

    // cross-pipe merge, lower pipe wins; one register per pipe keeps alignment
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        xh_q <= 1'b0;
        xi_q <= '0;
      end else if (p == 0) begin
        xh_q <= r_hit[p][NUM_STAGES];
        xi_q <= r_id[p][NUM_STAGES];
      end else begin
        xh_q <= x_hit[(p == 0) ? 0 : p-1] | r_hit[p][NUM_STAGES];
        xi_q <= x_hit[(p == 0) ? 0 : p-1] ? x_id[(p == 0) ? 0 : p-1] : r_id[p][NUM_STAGES];
      end
    end
    assign x_hit[p] = xh_q;
    assign x_id[p]  = xi_q;
  end

  assign match_o = x_hit[NUM_PIPES-1];
  assign id_o    = x_id[NUM_PIPES-1];
endmodule

// File: rtl/match_array_chk.sv
module match_array_chk #(
  parameter int unsigned NUM_PIPES  = 2,
  parameter int unsigned NUM_STAGES = 2,
  parameter int unsigned SLOTS      = 4,
  parameter int unsigned CHAR_W     = 8,
  localparam int unsigned PW   = match_pkg::idx_w(NUM_PIPES),
  localparam int unsigned SW   = match_pkg::idx_w(NUM_STAGES),
  localparam int unsigned KW   = match_pkg::idx_w(SLOTS),
  localparam int unsigned ID_W = PW + SW + KW,
  localparam int unsigned LAT  = NUM_PIPES + NUM_STAGES + 1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic [CHAR_W-1:0] char_i,
  input logic              match_o,
  input logic [ID_W-1:0]   id_o
);
  logic [LAT-1:0]             vsr;
  logic [LAT-1:0][CHAR_W-1:0] csr;
  logic [PW-1:0]              p_f;
  logic [SW-1:0]              s_f;
  logic [KW-1:0]              k_f;
  logic [CHAR_W-1:0]          mask;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vsr <= '0;
      csr <= '0;
    end else begin
      vsr <= {vsr[LAT-2:0], valid_i};
      csr <= {csr[LAT-2:0], char_i};
    end
  end

  assign p_f = id_o[ID_W-1 -: PW];
  assign s_f = id_o[KW+SW-1 -: SW];
  assign k_f = id_o[KW-1:0];
  assign mask = CHAR_W'(match_pkg::flat_idx(p_f, s_f, k_f, NUM_STAGES, SLOTS) + 1);

  // R8
  idle_id_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !match_o |-> (id_o == '0));

  // R9
  match_needs_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_o |-> vsr[LAT-1]);

  // R3
  winner_mask_held_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_o |-> ((csr[LAT-1] & mask) == mask));

  // R7
  id_fields_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_o |-> ((32'(p_f) < NUM_PIPES) && (32'(s_f) < NUM_STAGES) && (32'(k_f) < SLOTS)));

  // R1
  reset_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (!match_o && id_o == '0));
endmodule

bind match_array match_array_chk #(
  .NUM_PIPES(NUM_PIPES), .NUM_STAGES(NUM_STAGES), .SLOTS(SLOTS), .CHAR_W(CHAR_W)
) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .valid_i (valid_i),
  .char_i  (char_i),
  .match_o (match_o),
  .id_o    (id_o)
);

// File: tb/match_array_test.sv
`timescale 1ns/1ps
module match_array_test;
  localparam int P = 2, S = 2, N = 4, CW = 8;
  localparam int PW = 1, SW = 1, KW = 2, IDW = 4;
  localparam int LAT = P + S + 1;
  localparam int TOT = P * S * N;
  localparam int NDIR = 6;
  localparam int NST = NDIR + 256;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic valid_i = 1'b0;
  logic [CW-1:0] char_i = '0;
  logic match_o;
  logic [IDW-1:0] id_o;

  int checks = 0;
  int errors = 0;

  logic [CW-1:0] st_chr [NST];
  logic          st_vld [NST];
  string         st_tag [NST];

  always #2.5 clk = ~clk;

  match_array #(.NUM_PIPES(P), .NUM_STAGES(S), .SLOTS(N), .CHAR_W(CW)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .char_i(char_i),
    .match_o(match_o), .id_o(id_o)
  );

  task automatic expect_res(input logic [CW-1:0] c, input logic v,
                            output logic hit, output logic [IDW-1:0] id);
    int win;
    win = -1;
    if (v) begin
      for (int g = TOT - 1; g >= 0; g--) begin
        int m;
        m = (g + 1) & 8'hFF;
        if ((int'(c) & m) == m) win = g;
      end
    end
    hit = (win >= 0);
    id  = '0;
    if (hit) begin
      int pp, ss, kk;
      pp = win / (S * N);
      ss = (win / N) % S;
      kk = win % N;
      id = IDW'((pp << (SW + KW)) | (ss << KW) | kk);
    end
  endtask

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  initial begin
    st_chr[0] = 8'h03; st_vld[0] = 1'b1; st_tag[0] = "R4";
    st_chr[1] = 8'h0C; st_vld[1] = 1'b1; st_tag[1] = "R5";
    st_chr[2] = 8'h18; st_vld[2] = 1'b1; st_tag[2] = "R6";
    st_chr[3] = 8'h10; st_vld[3] = 1'b1; st_tag[3] = "R7";
    st_chr[4] = 8'h00; st_vld[4] = 1'b1; st_tag[4] = "R8";
    st_chr[5] = 8'hFF; st_vld[5] = 1'b0; st_tag[5] = "R9";
    for (int c = 0; c < 256; c++) begin
      st_chr[NDIR + c] = CW'(c);
      st_vld[NDIR + c] = (c % 7) != 3;
      st_tag[NDIR + c] = (c % 7) == 3 ? "R9 sweep" : "R2 R3 R10 sweep";
    end

    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 reset match", int'(match_o), 0);
    check("R1 reset id", int'(id_o), 0);
    @(posedge clk);
    #1 rst_ni = 1'b1;
    @(negedge clk);
    check("R1 post-reset match", int'(match_o), 0);

    for (int i = 0; i < NST + LAT; i++) begin
      @(posedge clk);
      #1;
      if (i < NST) begin
        valid_i = st_vld[i];
        char_i  = st_chr[i];
      end else begin
        valid_i = 1'b0;
        char_i  = '0;
      end
      @(negedge clk);
      if (i >= LAT) begin
        logic eh;
        logic [IDW-1:0] ei;
        int j;
        j = i - LAT;
        expect_res(st_chr[j], st_vld[j], eh, ei);
        check({st_tag[j], " match"}, int'(match_o), int'(eh));
        check({st_tag[j], " id R7"}, int'(id_o), int'(ei));
      end
    end

    @(negedge clk);
    check("R9 idle after stream", int'(match_o), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #20000;
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule